// File: doc/BRIEF.md
# Prescaled Timer Counter

A 16-bit free-running timer for use as a periodic time base. It counts ticks from a selectable source: no source, every cycle of its own clock, or the rising edges of an external clock input after that input is synchronized. A power-of-two prescaler divides the selected source. The counter runs either upward against a modulo value and wraps to zero, or up and down between zero and the modulo value. Each overflow sets a sticky flag, which can drive an interrupt line or a one-cycle DMA request.

Software reaches the block through a small register port with three registers: control/status at address 0, counter at address 1 and modulo at address 2. A request is held on `bus_sel` until `bus_ready` is high. Reads of the counter take two extra cycles. All other accesses complete in the cycle they are presented.

Top module: `prescaled_timer`

## Requirements
- R1: Control bits [1:0] select the tick source: 00 gives no counting, 01 counts every clock, 10 counts each rising edge of `ext_clk` after a two-stage synchronizer, and 11 gives no counting.
- R2: Control bits [4:2] hold PS. The counter advances once per 2^PS source ticks, so PS values 0 to 7 give division by 1 to 128.
- R3: A control write changes PS (bits [4:2]) and the up-down bit (bit 5) only if the stored clock-mode field is 00 when the write happens. Otherwise those fields keep their values.
- R4: With bit 5 = 0, the counter steps 0, 1, ... up to the modulo value and then goes back to 0. The step back to 0 is an overflow.
- R5: With bit 5 = 1, the counter rises to the modulo value and then falls to 0. The step that leaves 0 going upward again is an overflow, so one period is 2×modulo ticks.
- R6: Control bit 7 is the overflow flag. It is set by an overflow and cleared by writing 1 to it. An overflow in the same cycle as the clear leaves it set.
- R7: `irq` is high exactly while control bit 6 (interrupt enable) and the overflow flag are both 1.
- R8: When bit 6 = 0 and bit 8 (DMA enable) = 1, `dma_req` pulses high for one cycle after each overflow. It stays low otherwise.
- R9: Reset clears the counter. A write of any value to address 1 also clears it to 0.
- R10: While `dbg_halt` is high and control bit 9 (run in debug) is 0, the counter does not change.
- R11: A read of address 1 raises `bus_ready` only in its third cycle. Writes and reads of other addresses are ready in their first cycle.
- R12: After a write of 00 to the clock-mode field while it is non-zero, the field reads its old value for one more cycle. It reads 00 after that cycle, and counting continues through that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request, held until ready |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 control, 1 counter, 2 modulo |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while ready |
| bus_ready | output | 1 | Access completes this cycle |
| ext_clk | input | 1 | External tick source, asynchronous |
| dbg_halt | input | 1 | Debug state active |
| irq | output | 1 | Overflow interrupt |
| dma_req | output | 1 | One-cycle overflow DMA request |

## Verification
On every cycle, the assertions check the following:
- the counter holds whenever no source is running or a debug halt applies;
- writes to the protected fields are refused while the timer is enabled;
- a counter write leaves zero;
- a counter read is never ready in its first cycle;
- the flag rises only on an overflow, and a DMA pulse never appears without the flag;
- the mode field keeps its old value for one cycle after a disable.

The bench scenarios are needed for the things a single-cycle property cannot show: the count values and overflow flag that the prescaler and modulo produce over long runs in both counting modes, edge counting through the synchronizer, and the number and spacing of DMA pulses.

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_ready,
  input  logic          ext_clk,
  input  logic          dbg_halt,
  output logic          irq,
  output logic          dma_req
);
  localparam int PRE_W = (1 << PS_W) - 1;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_MOD  = 2'd2;
  localparam logic [1:0] RD_WAIT = 2'd2;

  logic [1:0]       mode_q;
  logic             stop_q;
  logic [PS_W-1:0]  ps_q;
  logic             ud_q, ie_q, flag_q, dma_en_q, dbg_run_q, up_q, dma_q;
  logic [CNT_W-1:0] cnt_q, mod_q, cnt_nx;
  logic [PRE_W-1:0] pre_q, pre_mask;
  logic [2:0]       ext_s;
  logic [1:0]       wait_q;
  logic             up_nx, evt;

  wire wr_ctrl = bus_sel & bus_wr & (bus_addr == A_CTRL);
  wire wr_cnt  = bus_sel & bus_wr & (bus_addr == A_CNT);
  wire wr_mod  = bus_sel & bus_wr & (bus_addr == A_MOD);
  wire rd_cnt  = bus_sel & ~bus_wr & (bus_addr == A_CNT);

  wire ext_rise = ext_s[1] & ~ext_s[2];
  wire run  = (mode_q == 2'b01) | (mode_q == 2'b10);
  wire hold = dbg_halt & ~dbg_run_q;
  wire src  = ~hold & ((mode_q == 2'b01) | ((mode_q == 2'b10) & ext_rise));
  assign pre_mask = ~({PRE_W{1'b1}} << ps_q);
  wire tick = src & ((pre_q & pre_mask) == pre_mask);

  assign bus_ready = bus_sel & (~rd_cnt | (wait_q == RD_WAIT));
  assign irq       = ie_q & flag_q;
  assign dma_req   = dma_q;

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  always_comb begin
    cnt_nx = cnt_q;
    up_nx  = up_q;
    evt    = 1'b0;
    if (tick) begin
      if (mod_q == '0) begin
        cnt_nx = '0;
        up_nx  = 1'b1;
        evt    = 1'b1;
      end else if (!ud_q || up_q) begin
        if (cnt_q >= mod_q) begin
          if (ud_q) begin
            cnt_nx = mod_q - 1'b1;
            up_nx  = 1'b0;
          end else begin
            cnt_nx = '0;
            evt    = 1'b1;
          end
        end else begin
          cnt_nx = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_nx = {{(CNT_W-1){1'b0}}, 1'b1};
          up_nx  = 1'b1;
          evt    = 1'b1;
        end else begin
          cnt_nx = cnt_q - 1'b1;
        end
      end
    end
    if (wr_cnt) begin
      cnt_nx = '0;
      up_nx  = 1'b1;
      evt    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      up_q   <= 1'b1;
      pre_q  <= '0;
      ext_s  <= '0;
      wait_q <= '0;
      flag_q <= 1'b0;
      dma_q  <= 1'b0;
      mod_q  <= '1;
    end else begin
      cnt_q  <= cnt_nx;
      up_q   <= up_nx;
      ext_s  <= {ext_s[1:0], ext_clk};
      wait_q <= (rd_cnt && !bus_ready) ? wait_q + 1'b1 : 2'd0;
      flag_q <= evt | (flag_q & ~(wr_ctrl & bus_wdata[7]));
      dma_q  <= evt & ~ie_q & dma_en_q;
      if (!run || wr_cnt) pre_q <= '0;
      else if (src)       pre_q <= pre_q + 1'b1;
      if (wr_mod) mod_q <= bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= 2'b00;
      stop_q    <= 1'b0;
      ps_q      <= '0;
      ud_q      <= 1'b0;
      ie_q      <= 1'b0;
      dma_en_q  <= 1'b0;
      dbg_run_q <= 1'b0;
    end else if (wr_ctrl) begin
      ie_q      <= bus_wdata[6];
      dma_en_q  <= bus_wdata[8];
      dbg_run_q <= bus_wdata[9];
      if (mode_q == 2'b00) begin
        ps_q <= bus_wdata[2 +: PS_W];
        ud_q <= bus_wdata[5];
      end
      if (bus_wdata[1:0] != 2'b00) begin
        mode_q <= bus_wdata[1:0];
        stop_q <= 1'b0;
      end else if (stop_q) begin
        mode_q <= 2'b00;
        stop_q <= 1'b0;
      end else if (mode_q != 2'b00) begin
        stop_q <= 1'b1;
      end
    end else if (stop_q) begin
      mode_q <= 2'b00;
      stop_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = DW'({dbg_run_q, dma_en_q, flag_q, ie_q, ud_q, ps_q, mode_q});
      A_CNT:   bus_rdata = DW'(cnt_q);
      A_MOD:   bus_rdata = DW'(mod_q);
      default: bus_rdata = '0;
    endcase
  end
endmodule

module prescaled_timer_chk #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [1:0]       wd_mode,
  input logic             bus_ready,
  input logic             dbg_halt,
  input logic             dma_req,
  input logic [1:0]       mode_q,
  input logic             stop_q,
  input logic [PS_W-1:0]  ps_q,
  input logic             ud_q,
  input logic             dbg_run_q,
  input logic             flag_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [1:0]       wait_q,
  input logic             evt
);
  wire c_wr_ctrl = bus_sel & bus_wr & (bus_addr == 2'd0);
  wire c_wr_cnt  = bus_sel & bus_wr & (bus_addr == 2'd1);
  wire c_rd_cnt  = bus_sel & ~bus_wr & (bus_addr == 2'd1);
  wire c_running = (mode_q == 2'b01) | (mode_q == 2'b10);

  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_running && !c_wr_cnt) |=> $stable(cnt_q));
  a_r3_protect: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr_ctrl && mode_q != 2'b00) |=> ($stable(ps_q) && $stable(ud_q)));
  a_r6_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(evt));
  a_r8_dma_flag: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> flag_q);
  a_r9_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr_cnt |=> (cnt_q == '0));
  a_r10_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && !dbg_run_q && !c_wr_cnt) |=> $stable(cnt_q));
  a_r11_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd_cnt && wait_q == 2'd0) |-> !bus_ready);
  a_r12_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr_ctrl && wd_mode == 2'b00 && mode_q != 2'b00 && !stop_q) |=> $stable(mode_q));
endmodule

bind prescaled_timer prescaled_timer_chk #(.CNT_W(CNT_W), .PS_W(PS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wd_mode(bus_wdata[1:0]), .bus_ready(bus_ready), .dbg_halt(dbg_halt), .dma_req(dma_req),
  .mode_q(mode_q), .stop_q(stop_q), .ps_q(ps_q), .ud_q(ud_q), .dbg_run_q(dbg_run_q),
  .flag_q(flag_q), .cnt_q(cnt_q), .wait_q(wait_q), .evt(evt)
);

// File: tb/prescaled_timer_bench.sv
module prescaled_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, wr_en = 1'b0, ext = 1'b0, dbg = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic ready, irq, dma_req;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  localparam logic [1:0] CTRL = 2'd0, CNT = 2'd1, MOD = 2'd2;

  always #5 clk = ~clk;

  prescaled_timer u_prescaled_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr_en), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .bus_ready(ready), .ext_clk(ext),
    .dbg_halt(dbg), .irq(irq), .dma_req(dma_req)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d, output int w);
    sel = 1'b1; wr_en = 1'b0; addr = a; w = 0;
    #1;
    while (!ready) begin
      @(negedge clk);
      w++;
      #1;
    end
    d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  function automatic int exp_cnt(input int t, input int m, input bit ud);
    int p;
    if (!ud) return t % (m + 1);
    p = t % (2 * m);
    return (p <= m) ? p : 2 * m - p;
  endfunction

  function automatic bit exp_ovf(input int t, input int m, input bit ud);
    if (!ud) return (t / (m + 1)) > 0;
    return (t >= 1) && ((t - 1) >= 2 * m);
  endfunction

  task automatic run(input int ps, input bit ud, input int m, input int ncyc,
                     output logic [31:0] c, output logic [31:0] s);
    int w;
    logic [31:0] base;
    base = 32'(ps << 2) | 32'(ud << 5);
    wr(CTRL, base | 32'h80);
    wr(CNT, 32'd0);
    wr(MOD, 32'(m));
    wr(CTRL, base | 32'd1);
    repeat (ncyc) @(negedge clk);
    wr(CTRL, base);
    rd(CNT, c, w);
    rd(CTRL, s, w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R11 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] c, s;
    int w, t, pulses;
    bit prev, back2back;
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state, R11 wait states
    check(irq == 1'b0 && dma_req == 1'b0, "R9 reset outputs", {irq, dma_req}, 0);
    rd(CTRL, s, w);
    check(s == 32'd0, "R9 reset control", s, 0);
    check(w == 0, "R11 control read waits", w, 0);
    rd(CNT, c, w);
    check(c == 32'd0, "R9 reset counter", c, 0);
    check(w == 2, "R11 counter read waits", w, 2);
    rd(MOD, s, w);
    check(s == 32'h0000FFFF, "R4 reset modulo", s, 32'hFFFF);

    // R2 R4 R5 randomized runs
    for (int i = 0; i < 24; i++) begin
      int ps, m, n;
      bit ud;
      ps = int'($urandom_range(0, 3));
      m  = int'($urandom_range(1, 40));
      n  = int'($urandom_range(0, 300));
      ud = 1'($urandom_range(0, 1));
      run(ps, ud, m, n, c, s);
      t = (n + 2) >> ps;
      check(c == 32'(exp_cnt(t, m, ud)), ud ? "R5 R2 count" : "R4 R2 count", c, exp_cnt(t, m, ud));
      check(s[7] == exp_ovf(t, m, ud), "R6 flag after run", s[7], exp_ovf(t, m, ud));
      check(s[1:0] == 2'b00, "R12 mode cleared", s[1:0], 0);
    end

    // R2 largest divider
    run(7, 1'b0, 1000, 254, c, s);
    check(c == 32'd2, "R2 divide by 128", c, 2);

    // R12 delayed disable, R3 protection
    wr(CTRL, 32'h80);
    wr(CNT, 32'd0);
    wr(MOD, 32'd1000);
    wr(CTRL, 32'd1);
    wr(CTRL, 32'h1 | (32'd5 << 2) | 32'h20);
    rd(CTRL, s, w);
    check(s[5:2] == 4'd0, "R3 protected fields", s[5:2], 0);
    repeat (3) @(negedge clk);
    wr(CTRL, 32'd0);
    rd(CTRL, s, w);
    check(s[1:0] == 2'b01, "R12 old mode visible", s[1:0], 1);
    rd(CTRL, s, w);
    check(s[1:0] == 2'b00, "R12 mode after ack", s[1:0], 0);
    rd(CNT, c, w);
    check(c == 32'd7, "R12 counting through ack", c, 7);

    // R9 counter write clears
    wr(CNT, 32'h1234);
    rd(CNT, c, w);
    check(c == 32'd0, "R9 write clears", c, 0);

    // R1 reserved mode
    wr(CTRL, 32'd3);
    repeat (10) @(negedge clk);
    wr(CTRL, 32'd0);
    @(negedge clk);
    rd(CNT, c, w);
    check(c == 32'd0, "R1 reserved mode idle", c, 0);

    // R1 external edges
    wr(CTRL, 32'd2);
    for (int k = 0; k < 5; k++) begin
      ext = 1'b1; repeat (2) @(negedge clk);
      ext = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    wr(CTRL, 32'd0);
    rd(CNT, c, w);
    check(c == 32'd5, "R1 external edges", c, 5);

    // R10 debug halt
    wr(CNT, 32'd0);
    dbg = 1'b1;
    wr(CTRL, 32'd1);
    repeat (10) @(negedge clk);
    wr(CTRL, 32'd0);
    rd(CNT, c, w);
    check(c == 32'd0, "R10 halted", c, 0);
    wr(CTRL, 32'h201);
    repeat (8) @(negedge clk);
    wr(CTRL, 32'h200);
    rd(CNT, c, w);
    check(c == 32'd10, "R10 run in debug", c, 10);
    dbg = 1'b0;

    // R6 set wins over clear
    wr(CTRL, 32'h80);
    wr(CNT, 32'd0);
    wr(MOD, 32'd0);
    wr(CTRL, 32'd1);
    repeat (3) @(negedge clk);
    wr(CTRL, 32'h81);
    rd(CTRL, s, w);
    check(s[7] == 1'b1, "R6 set beats clear", s[7], 1);
    wr(CTRL, 32'd0);
    @(negedge clk);
    wr(CTRL, 32'h80);
    rd(CTRL, s, w);
    check(s[7] == 1'b0, "R6 write-one clear", s[7], 0);

    // R7 interrupt
    check(irq == 1'b0, "R7 irq idle", irq, 0);
    wr(CTRL, 32'd1);
    repeat (2) @(negedge clk);
    wr(CTRL, 32'd0);
    @(negedge clk);
    check(irq == 1'b0, "R7 irq masked", irq, 0);
    wr(CTRL, 32'h40);
    check(irq == 1'b1, "R7 irq enabled", irq, 1);
    wr(CTRL, 32'hC0);
    check(irq == 1'b0, "R7 irq after clear", irq, 0);

    // R8 DMA pulses
    for (int pass = 0; pass < 2; pass++) begin
      logic [31:0] en;
      en = (pass == 0) ? 32'h100 : 32'h140;
      wr(CTRL, en | 32'h80);
      wr(CNT, 32'd0);
      wr(MOD, 32'd3);
      wr(CTRL, en | 32'd1);
      pulses = 0; prev = 1'b0; back2back = 1'b0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (dma_req) pulses++;
        if (dma_req && prev) back2back = 1'b1;
        prev = dma_req;
      end
      wr(CTRL, en);
      check(pulses == ((pass == 0) ? 5 : 0), "R8 dma pulse count", pulses, (pass == 0) ? 5 : 0);
      check(!back2back, "R8 dma single cycle", back2back, 0);
      @(negedge clk);
      check(irq == (pass == 1), "R7 irq with dma enable", irq, pass == 1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule